// File: doc/BRIEF.md
# Multi-Ratio Clock Divider with Phase Select

The block takes one fast source clock and produces three groups of clock outputs. Group A has five copies running at one eighth of the source rate, group B has four copies at one quarter, and group C has two copies at one half. A single 3-bit counter, clocked by the source, generates all three rates, so every group edge falls on a source edge. A fifth copy of nothing is added. Each output is a flop on the source clock, so within a group all copies switch on the same edge.

A two-bit phase select moves group A alone by whole source periods: one period later, no shift, one period earlier or two periods earlier than the edge it would share with groups B and C. The select is captured only when the counter is about to wrap, so a new value becomes effective at the start of a group A period. A test input swaps the divider's source from the oscillator clock to the reference clock. The outputs then run at the reference rate divided by 8, 4 and 2. The reset is synchronous and active high, and it is sampled on whichever source is selected.

Top module: `tri_ratio_clkdiv`

## Requirements
- R1: Every group C output toggles on every source edge after reset release, giving the source rate divided by 2 at 50/50 duty. Its rising edges fall on the odd source edges counted from release: 1, 3, 5 and so on.
- R2: Every group B output has a period of 4 source edges and stays high for 2 of them. It rises on source edges 1, 5, 9 and so on after release, which is always an edge where group C also rises.
- R3: Every group A output has a period of 8 source edges and stays high for 4 of them.
- R4: All copies within a group carry the same level on every cycle.
- R5: A source edge that samples reset high drives all outputs to 0. The first edge after release drives every output that is due high to 1 on that same edge. With phase_sel = 2'b01, this means all three groups rise together on edge 1.
- R6: Bit 0 of phase_sel is the first select line and bit 1 is the second. The shift s it sets for group A is: 2'b00 gives s = +1 (one source period later), 2'b01 gives s = 0, 2'b10 gives s = -1, and 2'b11 gives s = -2. Counting source edges from release, group A then rises on edges 9+s, 17+s and so on.
- R7: The select is captured on the source edge where the counter holds its last value, and reset also loads it. The new shift applies from the next edge, which is edge 8k+1 after release, and not before.
- R8: With test_en high, the divider runs only from ref_clk edges at the ratios of R1 to R3. Edges of osc_clk then leave the outputs unchanged.
- R9: Groups B and C are never moved by phase_sel. Their edges stay the same for every select value and across select changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Fast oscillator clock, the normal divider source |
| ref_clk | input | 1 | Reference clock, the divider source in test mode |
| test_en | input | 1 | 1: divider runs from ref_clk; 0: from osc_clk |
| rst | input | 1 | Synchronous active-high reset, sampled on the selected source |
| phase_sel | input | 2 | Group A shift select, encoding per R6 |
| grp_a_o | output | A_N (5) | Group A copies, source divided by 8, shiftable |
| grp_b_o | output | B_N (4) | Group B copies, source divided by 4 |
| grp_c_o | output | C_N (2) | Group C copies, source divided by 2 |

## Verification
Every output is one register stage behind the counter. A level is therefore due on the same source edge that samples the counter state it comes from, and the first edge after reset release already shows the counter's zero state. A change of phase_sel shows at group A only on edge 8k+1 after release, which is up to eight source edges after the input moves. The bench keeps a per-edge model and compares against it 1 ns after each active source edge, on whichever clock test_en selects. It also counts edges between rises to check the periods, the high times and the group A offset for each select value.

// File: rtl/trdiv_pkg.sv
`timescale 1ns/1ps
package trdiv_pkg;

    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    typedef logic [CNT_W-1:0] phase_t;

    // phase select encoding, bit 0 = first select line
    typedef enum logic [1:0] {
        SH_LATE1  = 2'b00,
        SH_NONE   = 2'b01,
        SH_EARLY1 = 2'b10,
        SH_EARLY2 = 2'b11
    } shift_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } grp_lvl_t;

    // counter offset for a shift: a later edge subtracts, an earlier one adds
    function automatic phase_t phase_offset(input shift_e sh);
        case (sh)
            SH_LATE1:  phase_offset = CNT_LAST;
            SH_NONE:   phase_offset = '0;
            SH_EARLY1: phase_offset = phase_t'(1);
            default:   phase_offset = phase_t'(2);
        endcase
    endfunction

    // levels high in the lower half of each count so that all rise at zero
    function automatic grp_lvl_t grp_levels(input phase_t cnt, input phase_t off);
        phase_t sh;
        sh = cnt + off;
        grp_levels.a = ~sh[CNT_W-1];
        grp_levels.b = ~cnt[1];
        grp_levels.c = ~cnt[0];
    endfunction

endpackage

// File: rtl/trdiv_src_mux.sv
`timescale 1ns/1ps
module trdiv_src_mux (
    input  logic osc_clk,
    input  logic ref_clk,
    input  logic test_en,
    output logic src_clk
);
    // switched only while reset is held, see trade-offs
    assign src_clk = test_en ? ref_clk : osc_clk;
endmodule

// File: rtl/trdiv_counter.sv
`timescale 1ns/1ps
module trdiv_counter
    import trdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_t cnt,
    output logic   wrap_next
);
    phase_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + phase_t'(1);
    end

    assign cnt       = cnt_q;
    assign wrap_next = (cnt_q == CNT_LAST);

    // R5: reset returns the count to zero
    p_cnt_clear_r5: assert property (@(posedge clk) rst |=> (cnt_q == '0));

endmodule

// File: rtl/trdiv_phase.sv
`timescale 1ns/1ps
module trdiv_phase
    import trdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_in,
    input  logic       wrap_next,
    output phase_t     off
);
    phase_t off_q;

    always_ff @(posedge clk) begin
        if (rst || wrap_next) off_q <= phase_offset(shift_e'(sel_in));
    end

    assign off = off_q;

    // R7: between wraps the applied offset holds
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wrap_next |=> $stable(off_q));

    // R6: at a wrap the offset follows the select sampled there
    p_sel_take_r6: assert property (@(posedge clk) disable iff (rst)
        wrap_next |=> (off_q == phase_offset(shift_e'($past(sel_in)))));

endmodule

// File: rtl/trdiv_fanout.sv
`timescale 1ns/1ps
module trdiv_fanout
    import trdiv_pkg::*;
#(
    parameter int A_N = 5,
    parameter int B_N = 4,
    parameter int C_N = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  phase_t         cnt,
    input  phase_t         off,
    output logic [A_N-1:0] grp_a_o,
    output logic [B_N-1:0] grp_b_o,
    output logic [C_N-1:0] grp_c_o
);
    grp_lvl_t lvl;

    always_comb lvl = grp_levels(cnt, off);

    // one flop per pin so each copy is driven straight from a register
    for (genvar i = 0; i < A_N; i++) begin : g_a
        always_ff @(posedge clk) begin
            if (rst) grp_a_o[i] <= 1'b0;
            else     grp_a_o[i] <= lvl.a;
        end
    end

    for (genvar i = 0; i < B_N; i++) begin : g_b
        always_ff @(posedge clk) begin
            if (rst) grp_b_o[i] <= 1'b0;
            else     grp_b_o[i] <= lvl.b;
        end
    end

    for (genvar i = 0; i < C_N; i++) begin : g_c
        always_ff @(posedge clk) begin
            if (rst) grp_c_o[i] <= 1'b0;
            else     grp_c_o[i] <= lvl.c;
        end
    end

    // R1: group C toggles on every edge once running
    p_c_toggle_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (grp_c_o[0] != $past(grp_c_o[0])));

    // R2: group B changes only where group C rises
    p_b_on_c_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (grp_b_o[0] != $past(grp_b_o[0])))
        |-> (grp_c_o[0] && !$past(grp_c_o[0])));

    // R4: copies within each group agree
    p_copies_r4: assert property (@(posedge clk)
        ((grp_a_o == '0) || (grp_a_o == '1)) &&
        ((grp_b_o == '0) || (grp_b_o == '1)) &&
        ((grp_c_o == '0) || (grp_c_o == '1)));

    // R5: reset drives every pin low
    p_reset_low_r5: assert property (@(posedge clk)
        rst |=> ((grp_a_o == '0) && (grp_b_o == '0) && (grp_c_o == '0)));

endmodule

// File: rtl/tri_ratio_clkdiv.sv
`timescale 1ns/1ps
module tri_ratio_clkdiv
    import trdiv_pkg::*;
#(
    parameter int A_N = 5,
    parameter int B_N = 4,
    parameter int C_N = 2
) (
    input  logic           osc_clk,
    input  logic           ref_clk,
    input  logic           test_en,
    input  logic           rst,
    input  logic [1:0]     phase_sel,
    output logic [A_N-1:0] grp_a_o,
    output logic [B_N-1:0] grp_b_o,
    output logic [C_N-1:0] grp_c_o
);
    logic   src_clk;
    phase_t cnt;
    phase_t off;
    logic   wrap_next;

    trdiv_src_mux u_mux (
        .osc_clk (osc_clk),
        .ref_clk (ref_clk),
        .test_en (test_en),
        .src_clk (src_clk)
    );

    trdiv_counter u_cnt (
        .clk       (src_clk),
        .rst       (rst),
        .cnt       (cnt),
        .wrap_next (wrap_next)
    );

    trdiv_phase u_phase (
        .clk       (src_clk),
        .rst       (rst),
        .sel_in    (phase_sel),
        .wrap_next (wrap_next),
        .off       (off)
    );

    trdiv_fanout #(.A_N(A_N), .B_N(B_N), .C_N(C_N)) u_fan (
        .clk     (src_clk),
        .rst     (rst),
        .cnt     (cnt),
        .off     (off),
        .grp_a_o (grp_a_o),
        .grp_b_o (grp_b_o),
        .grp_c_o (grp_c_o)
    );

endmodule

// File: tb/tri_ratio_clkdiv_test.sv
`timescale 1ns/1ps
module tri_ratio_clkdiv_test;

    localparam int A_N = 5;
    localparam int B_N = 4;
    localparam int C_N = 2;

    logic osc_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic test_en = 1'b0;
    logic rst     = 1'b1;
    logic [1:0] sel = 2'b01;
    logic [A_N-1:0] grp_a_o;
    logic [B_N-1:0] grp_b_o;
    logic [C_N-1:0] grp_c_o;

    always #2 osc_clk = ~osc_clk;   // 250 MHz
    always #7 ref_clk = ~ref_clk;

    tri_ratio_clkdiv #(.A_N(A_N), .B_N(B_N), .C_N(C_N)) uut (
        .osc_clk   (osc_clk),
        .ref_clk   (ref_clk),
        .test_en   (test_en),
        .rst       (rst),
        .phase_sel (sel),
        .grp_a_o   (grp_a_o),
        .grp_b_o   (grp_b_o),
        .grp_c_o   (grp_c_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // model state
    logic [2:0] m_cnt = 3'd0;
    logic [1:0] m_sel = 2'b01;
    logic m_a = 0, m_b = 0, m_c = 0;
    int e_idx = 0;

    // edge trackers
    int a_r1, a_r2, b_r1, b_r2, c_r1, c_r2, a_hi, b_hi, c_hi;
    logic a_pv = 0, b_pv = 0, c_pv = 0;

    function automatic logic [2:0] bench_off(input logic [1:0] s);
        case (s)
            2'b00:   return 3'd7;
            2'b01:   return 3'd0;
            2'b10:   return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    function automatic int shift_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 0;
            2'b10:   return -1;
            default: return -2;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic clr_track();
        a_r1 = -1; a_r2 = -1; b_r1 = -1; b_r2 = -1; c_r1 = -1; c_r2 = -1;
        a_hi = 0; b_hi = 0; c_hi = 0;
    endtask

    task automatic tick();
        logic [2:0] v;
        if (test_en) @(posedge ref_clk); else @(posedge osc_clk);
        if (rst) begin
            m_cnt = 3'd0; m_sel = sel; m_a = 0; m_b = 0; m_c = 0; e_idx = 0;
        end else begin
            e_idx++;
            m_c = ~m_cnt[0];
            m_b = ~m_cnt[1];
            v   = m_cnt + bench_off(m_sel);
            m_a = ~v[2];
            if (m_cnt == 3'd7) m_sel = sel;
            m_cnt = m_cnt + 3'd1;
        end
        #1;
        check(grp_c_o == {C_N{m_c}}, "R1", "group C level", int'(grp_c_o), int'({C_N{m_c}}));
        check(grp_b_o == {B_N{m_b}}, "R2", "group B level", int'(grp_b_o), int'({B_N{m_b}}));
        check(grp_a_o == {A_N{m_a}}, "R3", "group A level", int'(grp_a_o), int'({A_N{m_a}}));
        check((grp_a_o == '0 || grp_a_o == '1) && (grp_b_o == '0 || grp_b_o == '1) &&
              (grp_c_o == '0 || grp_c_o == '1), "R4", "copies equal",
              int'(grp_a_o), int'({A_N{grp_a_o[0]}}));
        if (!rst && e_idx >= 6) begin
            if (grp_a_o[0] && !a_pv) begin if (a_r1 < 0) a_r1 = e_idx; else if (a_r2 < 0) a_r2 = e_idx; end
            if (grp_b_o[0] && !b_pv) begin if (b_r1 < 0) b_r1 = e_idx; else if (b_r2 < 0) b_r2 = e_idx; end
            if (grp_c_o[0] && !c_pv) begin if (c_r1 < 0) c_r1 = e_idx; else if (c_r2 < 0) c_r2 = e_idx; end
        end
        if (!rst && e_idx >= 9 && e_idx <= 24) begin
            a_hi += int'(grp_a_o[0]); b_hi += int'(grp_b_o[0]); c_hi += int'(grp_c_o[0]);
        end
        a_pv = grp_a_o[0]; b_pv = grp_b_o[0]; c_pv = grp_c_o[0];
    endtask

    // one directed segment: reset, release, 24 edges, measure
    task automatic run_seg(input logic [1:0] s, input logic mode);
        int sh;
        sh = shift_of(s);
        rst = 1; test_en = mode; sel = s;
        clr_track();
        repeat (3) tick();
        check(grp_a_o == '0 && grp_b_o == '0 && grp_c_o == '0, "R5", "outputs low in reset",
              int'({grp_a_o, grp_b_o, grp_c_o}), 0);
        rst = 0;
        tick();
        check(grp_b_o[0] && grp_c_o[0], "R5", "B and C high on first edge",
              int'({grp_b_o[0], grp_c_o[0]}), 3);
        check(grp_a_o[0] == (s != 2'b00), "R5", "A level on first edge",
              int'(grp_a_o[0]), int'(s != 2'b00));
        for (int k = 0; k < 23; k++) begin
            tick();
            if (mode && k == 5) begin
                logic [A_N+B_N+C_N-1:0] snap;
                snap = {grp_a_o, grp_b_o, grp_c_o};
                @(posedge osc_clk); @(posedge osc_clk); #0.5;
                check({grp_a_o, grp_b_o, grp_c_o} == snap, "R8", "stable across osc edges",
                      int'({grp_a_o, grp_b_o, grp_c_o}), int'(snap));
            end
        end
        check(c_r1 == 7 && c_r2 == 9, "R1", "C rise edges", c_r1 * 100 + c_r2, 709);
        check(b_r1 == 9 && b_r2 == 13, "R9", "B rise edges unshifted", b_r1 * 100 + b_r2, 913);
        check(a_r1 == 9 + sh, "R6", "A first rise edge", a_r1, 9 + sh);
        check(a_r2 - a_r1 == 8, "R3", "A period", a_r2 - a_r1, 8);
        check(a_hi == 8 && b_hi == 8 && c_hi == 8, "R3", "duty high count A/B/C",
              a_hi * 10000 + b_hi * 100 + c_hi, 80808);
        if (mode) check(a_r2 - a_r1 == 8 && b_r2 - b_r1 == 4, "R8", "test-mode ratios",
                        (a_r2 - a_r1) * 10 + (b_r2 - b_r1), 84);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7193);
        clr_track();

        // directed: each select in normal mode, then test mode
        for (int s = 0; s < 4; s++) run_seg(2'(s), 1'b0);
        run_seg(2'b01, 1'b1);
        run_seg(2'b10, 1'b1);

        // R7: select change mid-period waits for the wrap
        rst = 1; test_en = 0; sel = 2'b01; clr_track();
        repeat (2) tick();
        rst = 0;
        repeat (11) tick();
        sel = 2'b11;
        repeat (4) tick();   // edge 15
        check(grp_a_o[0] == 1'b0, "R7", "A low at edge 15 (old shift kept)", int'(grp_a_o[0]), 0);
        tick();              // edge 16
        check(grp_a_o[0] == 1'b0, "R7", "A low at edge 16", int'(grp_a_o[0]), 0);
        tick();              // edge 17
        check(grp_a_o[0] == 1'b1, "R7", "A high at edge 17", int'(grp_a_o[0]), 1);
        repeat (5) tick();   // edge 22
        check(grp_a_o[0] == 1'b0, "R7", "A low at edge 22", int'(grp_a_o[0]), 0);
        tick();              // edge 23: new shift -2
        check(grp_a_o[0] == 1'b1, "R7", "A rises at edge 23 with new shift", int'(grp_a_o[0]), 1);
        check(grp_b_o[0] == 1'b0 && grp_c_o[0] == 1'b1, "R9", "B/C unmoved at edge 23",
              int'({grp_b_o[0], grp_c_o[0]}), 1);

        // constrained random segments checked against the model
        for (int it = 0; it < 40; it++) begin
            int len;
            rst = 1;
            test_en = (($urandom % 4) == 0);
            sel = 2'($urandom);
            repeat (2) tick();
            rst = 0;
            len = 10 + int'($urandom % 60);
            for (int k = 0; k < len; k++) begin
                if (($urandom % 6) == 0) sel = 2'($urandom);
                rst = (($urandom % 50) == 0);
                tick();
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule